// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock Registers

This block puts a calendar clock behind a byte-wide memory bus. The bus has active-low chip-enable, write-enable and output-enable strobes, a 19-bit address and separate 8-bit write and read data. The eight highest addresses select a control byte and seven packed-BCD time fields. Every other address is forwarded to an external SRAM port. A clock-enable at 32.768 kHz is divided down to a one-second tick. On each tick the internal counters for seconds, minutes, hours (24-hour), weekday, date, month and two-digit year advance together in a single cycle. Month lengths and leap Februaries are handled automatically.

The host never reads the running counters directly. It reads a visible copy that follows the counters one clock later. Setting the halt bit in the control byte freezes that copy so that the host can read a coherent snapshot, while timekeeping continues underneath. Clearing the bit reloads every visible field at once. When the power-good input is low, the block refuses all access.

The bus carries no back-pressure. There is no valid/ready pair: an access that holds the strobes across one rising clock edge completes in that cycle. Read data is combinational from the strobes and the address.

Top module: `bcd_clock_regs`

## Requirements
- R1: An address whose upper 16 bits are all ones selects an internal register, indexed by addr[2:0]: 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 date, 6 month, 7 year. Any other address drives the SRAM port instead: its active-low strobes follow the bus strobes, it copies addr and wdata, and reads return sram_rdata. During a register access all SRAM strobes stay high.
- R2: After reset the fields read control 00, seconds 00, minutes 00, hours 00, weekday 01, date 01, month 01 and year 00.
- R3: A tick occurs on every DIV-th cycle in which osc_en is high. Each tick advances seconds by one in packed BCD.
- R4: Seconds 59 wrap to 00 and carry into minutes. Minutes 59 wrap to 00 and carry into hours. Hours 23 wrap to 00 and carry into weekday (07 wraps to 01) and into date.
- R5: Date wraps to 01 and carries into month after 30 in months 04, 06, 09 and 11, after 31 in the other months, and after 28 or 29 in month 02. Month 12 wraps to 01 and carries into year, and year 99 wraps to 00.
- R6: February has 29 days when the BCD year value is divisible by 4 (00 included) and 28 days otherwise.
- R7: A bus write to index 1..7 loads that counter field. When a write and a tick fall in the same cycle, the write wins and the tick is dropped for that cycle.
- R8: Writing bit 6 of the control byte as 1 holds all visible time fields at their current values while the bit stays 1, and the internal counters keep advancing. A control read returns bit 6 with all other bits 0.
- R9: Writing bit 6 back to 0 reloads all seven visible fields from the counters on the next clock edge, including every tick that passed during the hold.
- R10: While not held, each visible field equals its counter as it stood one clock earlier.
- R11: While pwr_good is low, rdata is 00, all SRAM strobes are high, and bus writes change no register.
- R12: rdata is 00 unless ce_n and oe_n are low and we_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_en | input | 1 | 32.768 kHz clock-enable pulse |
| pwr_good | input | 1 | Supply in tolerance; low blocks every access |
| ce_n | input | 1 | Bus chip enable, active low |
| we_n | input | 1 | Bus write enable, active low |
| oe_n | input | 1 | Bus output enable, active low |
| addr | input | 19 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 00 when not reading |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_addr | output | 19 | SRAM address |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data |

## Verification
Read data and SRAM strobes are combinational, so the bench samples them 1 ns after it drives the strobes at a falling edge. A register write lands at the next rising edge and shows up in the visible copy one edge later, so every write task waits two rising edges before returning. A tick that falls on the last enabled cycle updates the counters at that edge and the visible copy at the following edge, so reads after a tick run always come one extra edge later. The bench applies ticks only in whole multiples of DIV with osc_en gated, which keeps the divider phase known and each expected time exact.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hr;
    logic [7:0] day;
    logic [7:0] date;
    logic [7:0] mon;
    logic [7:0] yr;
  } rtc_time_t;

  localparam int NUM_REGS  = 8;
  localparam int IDX_W     = $clog2(NUM_REGS);
  localparam int HALT_BIT  = 6;

  localparam logic [IDX_W-1:0] IX_CTRL = 3'd0;
  localparam logic [IDX_W-1:0] IX_SEC  = 3'd1;
  localparam logic [IDX_W-1:0] IX_MIN  = 3'd2;
  localparam logic [IDX_W-1:0] IX_HR   = 3'd3;
  localparam logic [IDX_W-1:0] IX_DAY  = 3'd4;
  localparam logic [IDX_W-1:0] IX_DATE = 3'd5;
  localparam logic [IDX_W-1:0] IX_MON  = 3'd6;
  localparam logic [IDX_W-1:0] IX_YR   = 3'd7;

  localparam rtc_time_t TIME_RST = '{sec: 8'h00, min: 8'h00, hr: 8'h00,
                                     day: 8'h01, date: 8'h01, mon: 8'h01,
                                     yr: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // A two-digit BCD value is a multiple of 4 when the tens digit is even and
  // the units are 0/4/8, or the tens digit is odd and the units are 2/6.
  function automatic logic bcd_div4(input logic [7:0] v);
    if (v[4]) return (v[3:0] == 4'd2) || (v[3:0] == 4'd6);
    else      return (v[3:0] == 4'd0) || (v[3:0] == 4'd4) || (v[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return bcd_div4(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = osc_en && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else if (osc_en)  cnt_q <= cnt_q + CW'(1);
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  output rtc_time_t        now
);
  rtc_time_t nxt;
  logic [7:0] last_date;
  logic c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    last_date = month_last(now.mon, now.yr);
    c_min = (now.sec == 8'h59);
    c_hr  = c_min && (now.min == 8'h59);
    c_day = c_hr  && (now.hr  == 8'h23);
    c_mon = c_day && (now.date == last_date);
    c_yr  = c_mon && (now.mon == 8'h12);

    nxt      = now;
    nxt.sec  = c_min ? 8'h00 : bcd_inc(now.sec);
    if (c_min) nxt.min  = c_hr  ? 8'h00 : bcd_inc(now.min);
    if (c_hr)  nxt.hr   = c_day ? 8'h00 : bcd_inc(now.hr);
    if (c_day) nxt.day  = (now.day == 8'h07) ? 8'h01 : bcd_inc(now.day);
    if (c_day) nxt.date = c_mon ? 8'h01 : bcd_inc(now.date);
    if (c_mon) nxt.mon  = c_yr  ? 8'h01 : bcd_inc(now.mon);
    if (c_yr)  nxt.yr   = (now.yr == 8'h99) ? 8'h00 : bcd_inc(now.yr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now <= TIME_RST;
    end else if (wr_en) begin
      case (wr_idx)
        IX_SEC:  now.sec  <= wr_data;
        IX_MIN:  now.min  <= wr_data;
        IX_HR:   now.hr   <= wr_data;
        IX_DAY:  now.day  <= wr_data;
        IX_DATE: now.date <= wr_data;
        IX_MON:  now.mon  <= wr_data;
        IX_YR:   now.yr   <= wr_data;
        default: ;
      endcase
    end else if (tick) begin
      now <= nxt;
    end
  end

  // R3
  sec_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en) |=> (now.sec != $past(now.sec)));
  // R5
  date_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && now.date == last_date && now.hr == 8'h23 &&
     now.min == 8'h59 && now.sec == 8'h59) |=> (now.date == 8'h01));
  // R7
  tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(now));
endmodule

// File: rtl/rtc_vis_buffer.sv
module rtc_vis_buffer
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      halt,
  input  rtc_time_t now,
  output rtc_time_t vis
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vis <= TIME_RST;
    else if (!halt) vis <= now;
  end

  // R10
  vis_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(halt) |-> (vis == $past(now)));
  // R8
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(halt) |-> $stable(vis));
endmodule

// File: rtl/bcd_clock_regs.sv
module bcd_clock_regs
  import rtc_pkg::*;
#(
  parameter int DIV = 32768,
  parameter int AW  = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          osc_en,
  input  logic          pwr_good,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          sram_ce_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [AW-1:0] sram_addr,
  output logic [7:0]    sram_wdata,
  input  logic [7:0]    sram_rdata
);
  logic             is_reg, acc, wr, rd, tick, halt_q, cnt_wr;
  logic [IDX_W-1:0] idx;
  rtc_time_t        now, vis;
  logic [7:0]       reg_rd;

  assign idx    = addr[IDX_W-1:0];
  assign is_reg = &addr[AW-1:IDX_W];
  assign acc    = !ce_n && pwr_good;
  assign wr     = acc && !we_n;
  assign rd     = acc && we_n && !oe_n;
  assign cnt_wr = wr && is_reg && (idx != IX_CTRL);

  rtc_tick_div #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .tick(tick)
  );

  rtc_cal_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(cnt_wr),
    .wr_idx(idx), .wr_data(wdata), .now(now)
  );

  rtc_vis_buffer u_vis (
    .clk(clk), .rst_n(rst_n), .halt(halt_q), .now(now), .vis(vis)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               halt_q <= 1'b0;
    else if (wr && is_reg && idx == IX_CTRL)  halt_q <= wdata[HALT_BIT];
  end

  always_comb begin
    case (idx)
      IX_SEC:  reg_rd = vis.sec;
      IX_MIN:  reg_rd = vis.min;
      IX_HR:   reg_rd = vis.hr;
      IX_DAY:  reg_rd = vis.day;
      IX_DATE: reg_rd = vis.date;
      IX_MON:  reg_rd = vis.mon;
      IX_YR:   reg_rd = vis.yr;
      default: begin
        reg_rd = 8'h00;
        reg_rd[HALT_BIT] = halt_q;
      end
    endcase
  end

  assign rdata      = !rd ? 8'h00 : (is_reg ? reg_rd : sram_rdata);
  assign sram_ce_n  = !(acc && !is_reg);
  assign sram_we_n  = !(wr  && !is_reg);
  assign sram_oe_n  = !(rd  && !is_reg);
  assign sram_addr  = addr;
  assign sram_wdata = wdata;

  // R11
  pg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |-> (rdata == 8'h00 && sram_ce_n && sram_we_n && sram_oe_n));
  // R11
  pg_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_good && !tick) |=> ($stable(now) && $stable(halt_q)));
  // R1
  reg_sram_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_reg |-> (sram_ce_n && sram_we_n && sram_oe_n));
endmodule

// File: tb/test_bcd_clock_regs.sv
module test_bcd_clock_regs;
  localparam int DIV = 4;
  localparam logic [18:0] BASE = 19'h7FFF8;

  logic clk = 0, rst_n = 0, osc_en = 0, pwr_good = 1;
  logic ce_n = 1, we_n = 1, oe_n = 1;
  logic [18:0] addr = '0;
  logic [7:0] wdata = '0, rdata, sram_rdata = 8'h00;
  logic sram_ce_n, sram_we_n, sram_oe_n;
  logic [18:0] sram_addr;
  logic [7:0] sram_wdata;

  int n_chk = 0, n_bad = 0;
  int cur [8];
  int snap [8];
  logic last_we, last_ce;

  always #10 clk = ~clk;

  bcd_clock_regs #(.DIV(DIV), .AW(19)) i_bcd_clock_regs (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .pwr_good(pwr_good),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
    .sram_rdata(sram_rdata)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mlen(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  // index: 1 sec 2 min 3 hr 4 day 5 date 6 mon 7 yr
  task automatic advance();
    cur[1]++;
    if (cur[1] == 60) begin
      cur[1] = 0; cur[2]++;
      if (cur[2] == 60) begin
        cur[2] = 0; cur[3]++;
        if (cur[3] == 24) begin
          cur[3] = 0;
          cur[4] = (cur[4] == 7) ? 1 : cur[4] + 1;
          if (cur[5] == mlen(cur[6], cur[7])) begin
            cur[5] = 1;
            if (cur[6] == 12) begin
              cur[6] = 1;
              cur[7] = (cur[7] == 99) ? 0 : cur[7] + 1;
            end else cur[6]++;
          end else cur[5]++;
        end
      end
    end
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [18:0] a, input logic [7:0] d);
    ce_n = 0; we_n = 0; oe_n = 1; addr = a; wdata = d;
    #1; last_we = sram_we_n; last_ce = sram_ce_n;
    @(posedge clk); @(negedge clk);
    ce_n = 1; we_n = 1;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic bus_rd(input logic [18:0] a, output logic [7:0] d);
    ce_n = 0; we_n = 1; oe_n = 0; addr = a;
    #1; d = rdata; last_ce = sram_ce_n;
    ce_n = 1; oe_n = 1;
  endtask

  task automatic set_time(input int s, input int mi, input int h, input int dy,
                          input int dt, input int mo, input int y);
    cur[1] = s; cur[2] = mi; cur[3] = h; cur[4] = dy;
    cur[5] = dt; cur[6] = mo; cur[7] = y;
    for (int i = 1; i < 8; i++) bus_wr(BASE + 19'(i), bcd(cur[i]));
  endtask

  task automatic run_ticks(input int n);
    osc_en = 1;
    repeat (n * DIV) @(posedge clk);
    @(negedge clk);
    osc_en = 0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check_all(input string req);
    logic [7:0] d;
    for (int i = 1; i < 8; i++) begin
      bus_rd(BASE + 19'(i), d);
      chk(req, d, bcd(cur[i]));
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2 reset values
    bus_rd(BASE, d); chk("R2 ctrl", d, 8'h00);
    cur[1] = 0; cur[2] = 0; cur[3] = 0; cur[4] = 1; cur[5] = 1; cur[6] = 1; cur[7] = 0;
    check_all("R2");

    // R3 single tick from reset
    run_ticks(1); advance(); check_all("R3");

    // R7 write loads, visible after write task
    set_time(10, 20, 5, 3, 15, 6, 42); check_all("R7");

    // R4 carries through weekday 7 -> 1
    set_time(59, 59, 23, 7, 10, 3, 11); run_ticks(1); advance(); check_all("R4");
    chk("R4 day", bcd(cur[4]), 8'h01);

    // R5 month ends
    set_time(59, 59, 23, 2, 30, 4, 5); run_ticks(1); advance(); check_all("R5 apr");
    set_time(59, 59, 23, 2, 31, 1, 5); run_ticks(1); advance(); check_all("R5 jan");
    set_time(59, 59, 23, 5, 31, 12, 99); run_ticks(1); advance(); check_all("R5 year");
    chk("R5 yr00", bcd(cur[7]), 8'h00);

    // R6 leap and non-leap February
    set_time(59, 59, 23, 1, 28, 2, 24); run_ticks(1); advance(); check_all("R6 leap");
    chk("R6 29th", bcd(cur[5]), 8'h29);
    set_time(59, 59, 23, 1, 28, 2, 23); run_ticks(1); advance(); check_all("R6 plain");
    set_time(59, 59, 23, 1, 29, 2, 0); run_ticks(1); advance(); check_all("R6 y00");

    // R8 halt freezes visible copy; R9 reload on clear
    set_time(58, 59, 23, 6, 31, 12, 49);
    bus_wr(BASE, 8'h40);
    bus_rd(BASE, d); chk("R8 ctrl", d, 8'h40);
    bus_wr(BASE, 8'hFF);
    bus_rd(BASE, d); chk("R8 ctrl mask", d, 8'h40);
    for (int i = 1; i < 8; i++) snap[i] = cur[i];
    run_ticks(3);
    for (int k = 0; k < 3; k++) advance();
    for (int i = 1; i < 8; i++) begin
      bus_rd(BASE + 19'(i), d); chk("R8 frozen", d, bcd(snap[i]));
    end
    bus_wr(BASE, 8'h00);
    check_all("R9");
    bus_rd(BASE, d); chk("R9 ctrl", d, 8'h00);

    // R10 follow one edge after a tick (run_ticks waits that edge)
    run_ticks(2); advance(); advance(); check_all("R10");

    // R11 power-good low
    pwr_good = 0;
    bus_rd(BASE + 19'd1, d); chk("R11 rd", d, 8'h00);
    bus_wr(BASE + 19'd1, 8'h33);
    bus_wr(BASE, 8'h40);
    bus_wr(19'h00100, 8'h11); chk("R11 sram we", {7'd0, last_we}, 8'h01);
    pwr_good = 1;
    check_all("R11");
    bus_rd(BASE, d); chk("R11 ctrl", d, 8'h00);

    // R1 SRAM pass-through
    sram_rdata = 8'hA5;
    bus_rd(19'h12345, d); chk("R1 rd", d, 8'hA5);
    chk("R1 ce", {7'd0, last_ce}, 8'h00);
    bus_wr(19'h7FFF7, 8'h5A); chk("R1 we", {7'd0, last_we}, 8'h00);
    bus_rd(BASE + 19'd3, d); chk("R1 reg ce", {7'd0, last_ce}, 8'h01);
    ce_n = 0; we_n = 1; oe_n = 0; addr = 19'h01234; #1;
    chk("R1 addr", sram_addr[7:0], 8'h34);
    ce_n = 1; oe_n = 1;

    // R12 no read without strobes
    ce_n = 1; oe_n = 0; we_n = 1; addr = BASE + 19'd1; #1;
    chk("R12 ce", rdata, 8'h00);
    ce_n = 0; oe_n = 1; #1;
    chk("R12 oe", rdata, 8'h00);
    ce_n = 1; oe_n = 1;
    @(negedge clk);

    // Random rollover trials (R3 R4 R5 R6)
    for (int t = 0; t < 40; t++) begin
      int y, m, dt;
      y  = $urandom_range(99);
      m  = $urandom_range(12, 1);
      dt = ($urandom_range(1) == 1) ? mlen(m, y) : $urandom_range(mlen(m, y), 1);
      set_time(($urandom_range(1) == 1) ? 59 : $urandom_range(59),
               ($urandom_range(1) == 1) ? 59 : $urandom_range(59),
               ($urandom_range(1) == 1) ? 23 : $urandom_range(23),
               $urandom_range(7, 1), dt, m, y);
      run_ticks(1); advance(); check_all("R5 rand");
    end

    finish_run();
  end
endmodule